// File: doc/BRIEF.md
# Global-Chop Offset Cancellation Controller

This block sequences a chopped measurement around an ADC decimation filter so that the offset of the front end cancels. After a start it waits a fixed warm-up, then runs a chain of conversions. Each conversion waits a programmable settling delay, pulses the filter reset, lets three full decimation periods pass so the third-order filter settles, and then takes one filter sample. The input polarity select is normal for the first conversion and flips after every conversion.

The first settled sample after a start is held back. From the second sample on, every new sample is paired with the one before it. The controller outputs half their difference, signed so the true input polarity is kept. A constant offset seen by both polarities therefore drops out. In continuous mode the stream runs until the next start. In single-shot mode exactly one result is produced, and the block then returns to idle with polarity normal. A start at any time aborts the running sequence and begins a fresh one. All waits are counted in modulator-rate ticks. The delay code and the oversampling ratio are latched when the start is taken.

Top module: `gchop_ctrl`

## Requirements
- R1: After reset, `polarity`, `filt_rst` and `res_valid` are 0 and `result` is 0.
- R2: The first conversion after a start uses `polarity` = 0 (normal). Every later conversion uses the opposite polarity of the one before it. The polarity in force is the value present while `filt_rst` pulses.
- R3: Every conversion is preceded by exactly one single-cycle `filt_rst` pulse. Two pulses fall between a start and the first result, and one pulse falls between consecutive results.
- R4: The 3-bit `dly_code` selects a settling delay of 8·2^code ticks, from 8 to 1024.
- R5: The first settled conversion is withheld. The first `res_valid` follows the start by exactly 44 + 2·(D + 3·OSR) `mod_tick` ticks, where D comes from R4 and OSR is `osr`.
- R6: In continuous mode (`cont_mode` = 1), later results follow each other every D + 3·OSR ticks.
- R7: With N the sample of the normal-polarity conversion and I the sample of the inverted one in the latest pair, `result` = floor((N − I)/2). The difference is formed at SAMPLE_W+1 bits and shifted arithmetically, so full-scale inputs of either sign do not overflow. A sample is taken at the first cycle with `filt_valid` high once the settling window has elapsed.
- R8: In single-shot mode (`cont_mode` = 0), exactly one result is produced. After it, `polarity` stays 0 and no further result appears until the next start.
- R9: A `start` during a running sequence aborts it. No result from the aborted run appears, and timing restarts from the new start as in R5.
- R10: `res_valid` is a one-cycle pulse, and `result` changes only in a cycle where `res_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a chop sequence |
| cont_mode | input | 1 | 1 = continuous, 0 = single-shot; latched at start |
| dly_code | input | 3 | Settling delay code; latched at start |
| osr | input | OSR_W | Oversampling ratio in ticks per decimation period; latched at start |
| mod_tick | input | 1 | Modulator-rate tick, one cycle wide |
| filt_data | input | SAMPLE_W | Signed decimation filter output |
| filt_valid | input | 1 | Filter output is valid |
| polarity | output | 1 | Input polarity select, 0 = normal |
| filt_rst | output | 1 | Filter reset pulse |
| result | output | SAMPLE_W | Signed offset-corrected result |
| res_valid | output | 1 | One-cycle strobe for `result` |

## Verification
A polarity register that fails to toggle makes both samples of a pair equal, so the very next result reads zero instead of the input. A stuck pairing flag shows up either as a result appearing one conversion too early or as missing results, and the tick count between start and result exposes it. A wrong value in the delay or window count moves every result by a fixed number of ticks from the first output onward. A lost or doubled filter reset shows up at the reset pin within one conversion. A failure to return to idle in single-shot mode is seen as an extra strobe one conversion period later.

// File: rtl/gchop_pkg.sv
package gchop_pkg;

  typedef enum logic [2:0] {
    GC_IDLE,
    GC_WARM,
    GC_DELAY,
    GC_SETTLE,
    GC_GRAB
  } gc_state_e;

  // settling delay in ticks for a 3-bit code: base doubled per code step
  function automatic int unsigned gc_delay_ticks(input int unsigned base,
                                                 input logic [2:0] code);
    return base << code;
  endfunction

endpackage

// File: rtl/gchop_timer.sv
module gchop_timer #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  // last tick of the loaded span
  assign expire = tick && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/gchop_seq.sv
module gchop_seq
  import gchop_pkg::*;
#(
  parameter int CNT_W      = 18,
  parameter int OSR_W      = 16,
  parameter int DLY_BASE   = 8,
  parameter int WARM_TICKS = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont_mode,
  input  logic [2:0]       dly_code,
  input  logic [OSR_W-1:0] osr,
  input  logic             expire,
  input  logic             filt_valid,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             polarity,
  output logic             filt_rst,
  output logic             capture,
  output logic             emit
);

  gc_state_e        state_q, state_d;
  logic             pol_q, pol_d;
  logic             first_q, first_d;
  logic             cont_q, cont_d;
  logic             frst_q, frst_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] win_q, win_d;

  always_comb begin
    state_d  = state_q;
    pol_d    = pol_q;
    first_d  = first_q;
    cont_d   = cont_q;
    dly_d    = dly_q;
    win_d    = win_q;
    frst_d   = 1'b0;
    load     = 1'b0;
    load_val = dly_q;
    capture  = 1'b0;
    emit     = 1'b0;

    if (start) begin
      state_d  = GC_WARM;
      pol_d    = 1'b0;
      first_d  = 1'b1;
      cont_d   = cont_mode;
      dly_d    = CNT_W'(gc_delay_ticks(DLY_BASE, dly_code));
      win_d    = (CNT_W'(osr) << 1) + CNT_W'(osr);
      load     = 1'b1;
      load_val = CNT_W'(WARM_TICKS);
    end else begin
      case (state_q)
        GC_WARM: begin
          if (expire) begin
            state_d  = GC_DELAY;
            load     = 1'b1;
            load_val = dly_q;
          end
        end
        GC_DELAY: begin
          if (expire) begin
            state_d  = GC_SETTLE;
            load     = 1'b1;
            load_val = win_q;
            frst_d   = 1'b1;
          end
        end
        GC_SETTLE: begin
          if (expire) begin
            state_d = GC_GRAB;
          end
        end
        GC_GRAB: begin
          if (filt_valid) begin
            capture = 1'b1;
            emit    = !first_q;
            first_d = 1'b0;
            if (first_q || cont_q) begin
              state_d  = GC_DELAY;
              pol_d    = !pol_q;
              load     = 1'b1;
              load_val = dly_q;
            end else begin
              state_d = GC_IDLE;
              pol_d   = 1'b0;
            end
          end
        end
        default: begin
          state_d = GC_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GC_IDLE;
      pol_q   <= 1'b0;
      first_q <= 1'b1;
      cont_q  <= 1'b0;
      frst_q  <= 1'b0;
      dly_q   <= '0;
      win_q   <= '0;
    end else begin
      state_q <= state_d;
      pol_q   <= pol_d;
      first_q <= first_d;
      cont_q  <= cont_d;
      frst_q  <= frst_d;
      dly_q   <= dly_d;
      win_q   <= win_d;
    end
  end

  assign polarity = pol_q;
  assign filt_rst = frst_q;

endmodule

// File: rtl/gchop_combine.sv
module gchop_combine #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic                emit,
  input  logic                polarity,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] result,
  output logic                res_valid
);

  localparam int EXT_W = SAMPLE_W + 1;

  logic [SAMPLE_W-1:0]     norm_q, norm_d;
  logic [SAMPLE_W-1:0]     inv_q, inv_d;
  logic [SAMPLE_W-1:0]     res_q, res_d;
  logic                    vld_q;
  logic [EXT_W-1:0]        norm_x, inv_x;
  logic signed [EXT_W-1:0] diff;
  logic signed [EXT_W-1:0] half;

  always_comb begin
    // pair the new sample with the stored one of opposite polarity
    if (polarity) begin
      norm_x = {norm_q[SAMPLE_W-1], norm_q};
      inv_x  = {sample[SAMPLE_W-1], sample};
    end else begin
      norm_x = {sample[SAMPLE_W-1], sample};
      inv_x  = {inv_q[SAMPLE_W-1], inv_q};
    end
    diff = $signed(norm_x - inv_x);
    half = diff >>> 1;

    norm_d = norm_q;
    inv_d  = inv_q;
    if (capture && !polarity) begin
      norm_d = sample;
    end
    if (capture && polarity) begin
      inv_d = sample;
    end
    res_d = emit ? half[SAMPLE_W-1:0] : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q <= '0;
      inv_q  <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      norm_q <= norm_d;
      inv_q  <= inv_d;
      res_q  <= res_d;
      vld_q  <= emit;
    end
  end

  assign result    = res_q;
  assign res_valid = vld_q;

endmodule

// File: rtl/gchop_ctrl.sv
module gchop_ctrl #(
  parameter int SAMPLE_W   = 24,
  parameter int OSR_W      = 16,
  parameter int DLY_BASE   = 8,
  parameter int WARM_TICKS = 44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cont_mode,
  input  logic [2:0]          dly_code,
  input  logic [OSR_W-1:0]    osr,
  input  logic                mod_tick,
  input  logic [SAMPLE_W-1:0] filt_data,
  input  logic                filt_valid,
  output logic                polarity,
  output logic                filt_rst,
  output logic [SAMPLE_W-1:0] result,
  output logic                res_valid
);

  localparam int DLY_W  = $clog2((DLY_BASE << 7) + 1);
  localparam int WIN_W  = OSR_W + 2;
  localparam int WARM_W = $clog2(WARM_TICKS + 1);
  localparam int MAX_AB = (DLY_W > WIN_W) ? DLY_W : WIN_W;
  localparam int CNT_W  = (MAX_AB > WARM_W) ? MAX_AB : WARM_W;

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expire;
  logic             capture;
  logic             emit;
  logic             pol_int;

  gchop_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .tick     (mod_tick),
    .expire   (expire)
  );

  gchop_seq #(
    .CNT_W      (CNT_W),
    .OSR_W      (OSR_W),
    .DLY_BASE   (DLY_BASE),
    .WARM_TICKS (WARM_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cont_mode  (cont_mode),
    .dly_code   (dly_code),
    .osr        (osr),
    .expire     (expire),
    .filt_valid (filt_valid),
    .load       (load),
    .load_val   (load_val),
    .polarity   (pol_int),
    .filt_rst   (filt_rst),
    .capture    (capture),
    .emit       (emit)
  );

  gchop_combine #(
    .SAMPLE_W (SAMPLE_W)
  ) u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .emit      (emit),
    .polarity  (pol_int),
    .sample    (filt_data),
    .result    (result),
    .res_valid (res_valid)
  );

  assign polarity = pol_int;

endmodule

// File: rtl/gchop_ctrl_chk.sv
module gchop_ctrl_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                cont_mode,
  input logic                filt_valid,
  input logic                polarity,
  input logic                filt_rst,
  input logic [SAMPLE_W-1:0] result,
  input logic                res_valid
);

  logic       cont_seen_q;
  logic [1:0] rst_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_seen_q <= 1'b0;
      rst_seen_q  <= 2'd0;
    end else if (start) begin
      cont_seen_q <= cont_mode;
      rst_seen_q  <= 2'd0;
    end else if (filt_rst && (rst_seen_q != 2'd2)) begin
      rst_seen_q  <= rst_seen_q + 2'd1;
    end
  end

  assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    filt_rst |=> !filt_rst);

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> res_valid);

  assert_pol_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(polarity) |-> $past(filt_valid || start));

  assert_first_withheld_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rst_seen_q == 2'd2));

  assert_single_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cont_seen_q) |-> !polarity);

endmodule

bind gchop_ctrl gchop_ctrl_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (.*);

// File: tb/gchop_ctrl_test.sv
module gchop_ctrl_test;

  localparam int W  = 24;
  localparam int OW = 16;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          cont_mode;
  logic [2:0]    dly_code;
  logic [OW-1:0] osr;
  logic          mod_tick;
  logic [W-1:0]  filt_data;
  logic          filt_valid;
  logic          polarity;
  logic          filt_rst;
  logic [W-1:0]  result;
  logic          res_valid;

  logic signed [W-1:0] norm_val;
  logic signed [W-1:0] inv_val;

  typedef struct {
    logic [W-1:0] value;
    int           ticks;
    int           rsts;
    bit           first;
  } exp_t;

  exp_t sb[$];
  int   checks;
  int   errors;
  int   tick_cnt;
  int   rst_cnt;
  logic exp_pol;
  logic prev_valid;
  bit   finished;

  gchop_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cont_mode  (cont_mode),
    .dly_code   (dly_code),
    .osr        (osr),
    .mod_tick   (mod_tick),
    .filt_data  (filt_data),
    .filt_valid (filt_valid),
    .polarity   (polarity),
    .filt_rst   (filt_rst),
    .result     (result),
    .res_valid  (res_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // analog front end model: input plus offset, sign flipped by polarity
  always_comb filt_data = polarity ? inv_val : norm_val;

  initial begin
    mod_tick = 1'b0;
    forever begin
      for (int ph = 0; ph < 4; ph++) begin
        @(posedge clk);
        #1 mod_tick = (ph == 3);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] half_diff(input logic signed [W-1:0] n,
                                             input logic signed [W-1:0] i);
    logic [W:0] d;
    d = {n[W-1], n} - {i[W-1], i};
    return d[W:1];
  endfunction

  function automatic int conv_ticks(input int code, input int r);
    return (8 << code) + 3 * r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (start) begin
        tick_cnt = 0;
        rst_cnt  = 0;
        exp_pol  = 1'b0;
      end else begin
        if (filt_rst) begin
          check(polarity == exp_pol, "R2", "polarity at filter reset", polarity, exp_pol);
          exp_pol = !exp_pol;
          rst_cnt++;
        end
        if (res_valid) begin
          check(!prev_valid, "R10", "strobe width", 2, 1);
          if (sb.size() == 0) begin
            check(1'b0, "R8/R9", "unexpected result strobe", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(result == e.value, "R7", "result value",
                  $signed(result), $signed(e.value));
            check(tick_cnt == e.ticks, e.first ? "R5" : "R6",
                  "ticks since previous event", tick_cnt, e.ticks);
            check(rst_cnt == e.rsts, "R3", "filter resets in interval",
                  rst_cnt, e.rsts);
          end
          tick_cnt = 0;
          rst_cnt  = 0;
        end
        if (mod_tick) tick_cnt++;
      end
      prev_valid = res_valid;
    end
  end

  task automatic pulse_start();
    @(posedge clk);
    #2 start = 1'b1;
    @(posedge clk);
    #2 start = 1'b0;
  endtask

  task automatic run_case(input int code, input int r,
                          input logic signed [W-1:0] n,
                          input logic signed [W-1:0] i,
                          input int nout, input bit cont);
    int per;
    int lat;
    per = conv_ticks(code, r);
    lat = 44 + 2 * per;
    norm_val  = n;
    inv_val   = i;
    dly_code  = 3'(code);
    osr       = OW'(r);
    cont_mode = cont;
    pulse_start();
    for (int k = 0; k < nout; k++) begin
      exp_t e;
      e.value = half_diff(n, i);
      e.ticks = (k == 0) ? lat : per;
      e.rsts  = (k == 0) ? 2 : 1;
      e.first = (k == 0);
      sb.push_back(e);
    end
    while (sb.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    if (!cont) begin
      // wait beyond one more conversion; any strobe is flagged by the monitor
      repeat (4 * (per + 4)) @(posedge clk);
      #3 check(polarity == 1'b0, "R8", "polarity after single shot", polarity, 0);
      check(sb.size() == 0, "R8", "pending items", sb.size(), 0);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_sim();
  end

  initial begin
    checks = 0; errors = 0; tick_cnt = 0; rst_cnt = 0;
    exp_pol = 1'b0; prev_valid = 1'b0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; cont_mode = 1'b0; dly_code = 3'd0;
    osr = OW'(4); filt_valid = 1'b1; norm_val = '0; inv_val = '0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(polarity == 1'b0, "R1", "polarity", polarity, 0);
    check(filt_rst == 1'b0, "R1", "filter reset", filt_rst, 0);
    check(res_valid == 1'b0, "R1", "strobe", res_valid, 0);
    check(result == '0, "R1", "result", result, 0);

    // continuous, symmetric offset cancels (R4 code 0, R5, R6, R7)
    run_case(0, 4, 24'sd963, -24'sd1037, 3, 1'b1);
    // single shot with odd difference, floor rounding (R7, R8)
    run_case(2, 8, 24'sd3, 24'sd0, 1, 1'b0);
    // full-scale positive pair, no overflow (R7)
    run_case(1, 2, 24'sh7FFFFF, -24'sh800000, 2, 1'b1);
    // full-scale negative pair, single shot (R7)
    run_case(3, 1, -24'sh800000, 24'sh7FFFFF, 1, 1'b0);
    // negative odd result rounds toward minus infinity (R7)
    run_case(3, 1, 24'sd0, 24'sd3, 2, 1'b1);
    // R9 abort: start a run, restart it before its first result
    norm_val = 24'sd5000; inv_val = 24'sd0;
    dly_code = 3'd1; osr = OW'(4); cont_mode = 1'b1;
    pulse_start();
    repeat (200) @(posedge clk);
    run_case(0, 3, -24'sd700, 24'sd500, 2, 1'b1);
    // largest delay code (R4)
    run_case(7, 1, 24'sd100, -24'sd60, 1, 1'b0);

    repeat (10) @(posedge clk);
    finish_sim();
  end

endmodule